// File: doc/BRIEF.md
# Four-Warp Issue Scheduler with Barrier

This block decides which of four warps goes next into a SIMD pipeline. Each warp is a 2-bit ID plus a 32-bit program counter, and all threads of a warp run in lockstep. A kernel starts with a `start` pulse. The scheduler then loads every warp at the given start PC before any warp can issue. After that it offers one warp per cycle on a valid/ready issue port, unless the pipeline holds `stall` high.

When a warp finishes its trip through the pipeline, it comes back on the return port with its next PC and a reason code. The reason code sends the warp to one of three FIFO queues:

- the normal ready queue;
- the memory-return queue, which has issue priority;
- the barrier wait queue.

A warp parked in the wait queue stays inactive until all four warps have arrived. Then the whole wait queue drains into the normal queue, with each PC stepped past the sync instruction. A warp that returns with the exit code is retired. A one-cycle `done` pulse marks the retirement of the last warp.

The control FSM has five states:

- **ST_IDLE**: waits for `start`. On `start` it goes to ST_LOAD (transition *kick*).
- **ST_LOAD**: pushes warps 0 to 3, one per cycle. After the fourth push it goes to ST_RUN (*loaded*).
- **ST_RUN**: issues warps and accepts returns. On the fourth barrier arrival it goes to ST_RELEASE (*barrier_met*). When every warp has retired it goes to ST_DONE (*all_retired*).
- **ST_RELEASE**: moves the four parked warps into the normal queue, one per cycle. It then goes back to ST_RUN (*released*).
- **ST_DONE**: raises `done` for one cycle and then goes to ST_IDLE (*finish*).

Top module: `warp_sched`

## Requirements
- R1: Reset is synchronous and active high. After reset, `issue_valid`, `done` and `sync_err` are low and all queues are empty.
- R2: After a `start` pulse in ST_IDLE, four load cycles follow with no issue. Warps 0, 1, 2, 3 then issue in that order, each with `start_pc`.
- R3: While `stall` is high, `issue_valid` is low. No warp is lost, and the queued warps issue after `stall` falls.
- R4: A return with reason 0 (normal) puts the warp at the tail of the normal queue, carrying the returned PC.
- R5: A return with reason 1 (memory done) goes to the memory queue. A non-empty memory queue is always served before the normal queue.
- R6: A return with reason 2 (sync) parks the warp in the wait queue. No parked warp issues while fewer than four warps have arrived.
- R7: On the fourth sync arrival, the parked warps move to the normal queue in arrival order, one per cycle. Each takes its returned PC plus 4. Issue resumes after the fourth move.
- R8: If any arrival PC in a barrier round differs from the first arrival's PC, `sync_err` rises. It stays high until reset or the next `start`, and the release still happens.
- R9: A return with reason 3 (exit) retires the warp, which never issues again. `done` is high for exactly one cycle, in the cycle after the return that retires the last of the four warps.
- R10: No queue is ever pushed while full without a simultaneous pop, and no queue is popped while empty.
- R11: While `issue_valid` is high and `issue_ready` is low, the presented warp stays at the head of its queue and is offered again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Kernel start pulse, accepted in ST_IDLE |
| start_pc | input | 32 | Initial PC for all warps |
| stall | input | 1 | Pipeline stall, blocks issue this cycle |
| issue_valid | output | 1 | A warp is offered for issue |
| issue_ready | input | 1 | Pipeline accepts the offered warp |
| issue_wid | output | 2 | ID of the offered warp |
| issue_pc | output | 32 | PC of the offered warp |
| ret_valid | input | 1 | A warp returns from the pipeline |
| ret_wid | input | 2 | ID of the returning warp |
| ret_pc | input | 32 | Next PC, or PC of the sync instruction for reason 2 |
| ret_reason | input | 2 | 0 normal, 1 memory done, 2 sync, 3 exit |
| done | output | 1 | One-cycle pulse once all warps have retired |
| sync_err | output | 1 | Sticky flag for barrier PC mismatch |

## Verification
Some properties are checked by the assertions on every cycle:

- `stall` and the load and release states always block issue.
- A non-empty memory queue always wins the issue slot.
- `done` never lasts two cycles.
- `sync_err` holds once raised.
- Reaching the barrier always leads into the release state.
- The FIFOs never overflow or underflow.

The bench scenarios cover what needs a known history: the issue order after loading, the order when a normal and a memory return compete, and the held offer while `issue_ready` is low. They also confirm that parked warps stay invisible until the fourth arrival, and they check the released PCs in both the matching and the mismatching barrier round. Finally they check that `done` fires only after the last exit.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;
    typedef enum logic [1:0] {
        RSN_NORMAL = 2'd0,
        RSN_MEM    = 2'd1,
        RSN_SYNC   = 2'd2,
        RSN_EXIT   = 2'd3
    } reason_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_RUN,
        ST_RELEASE,
        ST_DONE
    } sched_state_e;

    localparam int Q_NORM = 0;
    localparam int Q_MEM  = 1;
    localparam int Q_WAIT = 2;
    localparam int NUM_Q  = 3;
endpackage

// File: rtl/sched_fifo.sv
module sched_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 34
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          full;

    assign empty = (cnt == '0);
    assign full  = (cnt == CW'(DEPTH));
    assign dout  = mem[rp];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) begin
                mem[wp] <= din;
                wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            end
            if (pop) begin
                rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            end
            if (push && !pop) cnt <= cnt + 1'b1;
            else if (pop && !push) cnt <= cnt - 1'b1;
        end
    end

    AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (push && full) |-> pop);  // R10
    AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);  // R10
endmodule

// File: rtl/sched_barrier.sv
module sched_barrier #(
    parameter int WARPS = 4,
    parameter int PC_W  = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            arrive,
    input  logic [PC_W-1:0] arrive_pc,
    output logic            all_in,
    output logic            mismatch
);
    localparam int CW = (WARPS > 2) ? $clog2(WARPS) : 1;

    logic [CW-1:0]   count;
    logic [PC_W-1:0] first_pc;

    assign all_in = arrive && (count == CW'(WARPS - 1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count    <= '0;
            first_pc <= '0;
            mismatch <= 1'b0;
        end else if (arrive) begin
            if (count == '0) first_pc <= arrive_pc;
            else if (arrive_pc != first_pc) mismatch <= 1'b1;
            count <= all_in ? '0 : count + 1'b1;
        end
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (mismatch && !clear) |=> mismatch);  // R8
endmodule

// File: rtl/warp_sched.sv
module warp_sched
    import warp_sched_pkg::*;
#(
    parameter int WARPS   = 4,
    parameter int WID_W   = 2,
    parameter int PC_W    = 32,
    parameter int PC_STEP = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [PC_W-1:0]  start_pc,
    input  logic             stall,
    output logic             issue_valid,
    input  logic             issue_ready,
    output logic [WID_W-1:0] issue_wid,
    output logic [PC_W-1:0]  issue_pc,
    input  logic             ret_valid,
    input  logic [WID_W-1:0] ret_wid,
    input  logic [PC_W-1:0]  ret_pc,
    input  logic [1:0]       ret_reason,
    output logic             done,
    output logic             sync_err
);
    localparam int W = WID_W + PC_W;

    sched_state_e state, nstate;
    logic [WID_W-1:0] step_cnt;
    logic [PC_W-1:0]  start_pc_q;
    logic [WARPS-1:0] retired, retired_nxt;

    logic [NUM_Q-1:0] q_push, q_pop, q_empty;
    logic [W-1:0]     q_din  [NUM_Q];
    logic [W-1:0]     q_dout [NUM_Q];

    logic    ret_ok, pick_mem, fire, all_in, kick, step_last;
    reason_e rsn;
    logic [W-1:0] sel;

    for (genvar g = 0; g < NUM_Q; g++) begin : g_q
        sched_fifo #(.DEPTH(WARPS), .W(W)) u_q (
            .clk(clk), .rst(rst), .push(q_push[g]), .din(q_din[g]),
            .pop(q_pop[g]), .dout(q_dout[g]), .empty(q_empty[g])
        );
    end

    sched_barrier #(.WARPS(WARPS), .PC_W(PC_W)) u_bar (
        .clk(clk), .rst(rst), .clear(kick), .arrive(q_push[Q_WAIT]),
        .arrive_pc(ret_pc), .all_in(all_in), .mismatch(sync_err)
    );

    assign rsn       = reason_e'(ret_reason);
    assign kick      = (state == ST_IDLE) && start;
    assign ret_ok    = ret_valid && (state == ST_RUN);
    assign step_last = (step_cnt == WID_W'(WARPS - 1));
    assign retired_nxt = retired
        | ((ret_ok && rsn == RSN_EXIT) ? (WARPS'(1) << ret_wid) : '0);

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nstate;
    end

    // next state
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:    if (start) nstate = ST_LOAD;
            ST_LOAD:    if (step_last) nstate = ST_RUN;
            ST_RUN: begin
                if (all_in) nstate = ST_RELEASE;
                else if (&retired_nxt) nstate = ST_DONE;
            end
            ST_RELEASE: if (step_last) nstate = ST_RUN;
            ST_DONE:    nstate = ST_IDLE;
            default:    nstate = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            step_cnt   <= '0;
            start_pc_q <= '0;
            retired    <= '0;
        end else begin
            if (kick) begin
                start_pc_q <= start_pc;
                retired    <= '0;
            end else begin
                retired <= retired_nxt;
            end
            if (state == ST_LOAD || state == ST_RELEASE)
                step_cnt <= step_last ? '0 : step_cnt + 1'b1;
        end
    end

    // outputs and queue control
    always_comb begin
        pick_mem    = !q_empty[Q_MEM];
        issue_valid = (state == ST_RUN) && !stall
                      && (!q_empty[Q_MEM] || !q_empty[Q_NORM]);
        sel         = pick_mem ? q_dout[Q_MEM] : q_dout[Q_NORM];
        issue_wid   = sel[W-1:PC_W];
        issue_pc    = sel[PC_W-1:0];
        fire        = issue_valid && issue_ready;
        done        = (state == ST_DONE);

        q_pop[Q_MEM]  = fire && pick_mem;
        q_pop[Q_NORM] = fire && !pick_mem;
        q_pop[Q_WAIT] = (state == ST_RELEASE);

        q_push[Q_MEM]  = ret_ok && (rsn == RSN_MEM);
        q_push[Q_WAIT] = ret_ok && (rsn == RSN_SYNC);
        q_push[Q_NORM] = (state == ST_LOAD) || (state == ST_RELEASE)
                         || (ret_ok && rsn == RSN_NORMAL);

        q_din[Q_MEM]  = {ret_wid, ret_pc};
        q_din[Q_WAIT] = {ret_wid, ret_pc};
        if (state == ST_LOAD)
            q_din[Q_NORM] = {step_cnt, start_pc_q};
        else if (state == ST_RELEASE)
            q_din[Q_NORM] = {q_dout[Q_WAIT][W-1:PC_W],
                             q_dout[Q_WAIT][PC_W-1:0] + PC_W'(PC_STEP)};
        else
            q_din[Q_NORM] = {ret_wid, ret_pc};
    end

    AST_STALL_NO_ISSUE: assert property (@(posedge clk) disable iff (rst)
        stall |-> !issue_valid);  // R3
    AST_FILL_NO_ISSUE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOAD || state == ST_RELEASE) |-> !issue_valid);  // R2
    AST_MEM_FIRST: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && !q_empty[Q_MEM]) |-> (issue_wid == q_dout[Q_MEM][W-1:PC_W]));  // R5
    AST_BARRIER_RELEASE: assert property (@(posedge clk) disable iff (rst)
        all_in |=> (state == ST_RELEASE && !q_empty[Q_WAIT]));  // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);  // R9
endmodule

// File: tb/warp_sched_test.sv
`timescale 1ns/1ps
module warp_sched_test;
    logic        clk = 1'b0;
    logic        rst, start, stall, issue_ready, ret_valid;
    logic [31:0] start_pc, ret_pc, issue_pc;
    logic [1:0]  ret_wid, ret_reason, issue_wid;
    logic        issue_valid, done, sync_err;

    int checks = 0;
    int errors = 0;

    logic [33:0] exp_q [$];
    string       exp_tag [$];

    always #2 clk = ~clk;  // 250 MHz

    warp_sched uut (
        .clk(clk), .rst(rst), .start(start), .start_pc(start_pc),
        .stall(stall), .issue_valid(issue_valid), .issue_ready(issue_ready),
        .issue_wid(issue_wid), .issue_pc(issue_pc), .ret_valid(ret_valid),
        .ret_wid(ret_wid), .ret_pc(ret_pc), .ret_reason(ret_reason),
        .done(done), .sync_err(sync_err)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic expect_issue(input logic [1:0] w, input logic [31:0] pc, input string tag);
        exp_q.push_back({w, pc});
        exp_tag.push_back(tag);
    endtask

    task automatic send_ret(input logic [1:0] w, input logic [31:0] pc, input logic [1:0] r);
        ret_valid = 1'b1; ret_wid = w; ret_pc = pc; ret_reason = r;
        @(negedge clk);
        ret_valid = 1'b0;
    endtask

    task automatic wait_drain(input string tag);
        for (int i = 0; i < 100 && exp_q.size() > 0; i++) @(negedge clk);
        @(negedge clk);
        chk({tag, " queue drained"}, 64'(exp_q.size()), 64'd0);
    endtask

    // monitor: compares each accepted issue against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (!rst && issue_valid && issue_ready) begin
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R6/R9 unexpected issue: actual %0h_%0h expected none",
                             issue_wid, issue_pc);
                end else begin
                    logic [33:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = exp_tag.pop_front();
                    chk(t, {30'd0, issue_wid, issue_pc}, {30'd0, e});
                end
            end
        end
    end

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; stall = 1'b1; issue_ready = 1'b1;
        ret_valid = 1'b0; ret_wid = '0; ret_pc = '0; ret_reason = '0;
        start_pc = 32'h100;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 issue_valid", issue_valid, 0);
        chk("R1 done", done, 0);
        chk("R1 sync_err", sync_err, 0);

        // R2/R3: load under stall
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int i = 0; i < 7; i++) begin
            @(negedge clk); #1;
            chk("R3 stall blocks issue", issue_valid, 0);
        end
        expect_issue(2'd0, 32'h100, "R2 load order w0");
        expect_issue(2'd1, 32'h100, "R2 load order w1");
        expect_issue(2'd2, 32'h100, "R2 load order w2");
        expect_issue(2'd3, 32'h100, "R2 load order w3");
        @(negedge clk); stall = 1'b0;
        wait_drain("R2");

        // R4/R5/R11: held offer and memory priority
        issue_ready = 1'b0;
        send_ret(2'd2, 32'h104, 2'd0);
        #1;
        chk("R11 offer w2", {issue_valid, issue_wid}, {1'b1, 2'd2});
        @(negedge clk); #1;
        chk("R11 offer held", {issue_valid, issue_wid, issue_pc}, {1'b1, 2'd2, 32'h104});
        @(negedge clk);
        send_ret(2'd1, 32'h200, 2'd1);
        #1;
        chk("R5 mem head offered", issue_wid, 2'd1);
        expect_issue(2'd1, 32'h200, "R5 mem first");
        expect_issue(2'd2, 32'h104, "R4 normal requeue");
        @(negedge clk); issue_ready = 1'b1;
        wait_drain("R5");

        // R6/R7: matching barrier
        send_ret(2'd0, 32'h300, 2'd2);
        send_ret(2'd1, 32'h300, 2'd2);
        send_ret(2'd2, 32'h300, 2'd2);
        #1;
        chk("R6 parked not issued", issue_valid, 0);
        expect_issue(2'd3, 32'h108, "R4 w3 normal while others parked");
        @(negedge clk);
        send_ret(2'd3, 32'h108, 2'd0);
        wait_drain("R6");
        #1;
        chk("R6 still parked", issue_valid, 0);
        expect_issue(2'd0, 32'h304, "R7 release w0");
        expect_issue(2'd1, 32'h304, "R7 release w1");
        expect_issue(2'd2, 32'h304, "R7 release w2");
        expect_issue(2'd3, 32'h304, "R7 release w3");
        @(negedge clk);
        send_ret(2'd3, 32'h300, 2'd2);
        wait_drain("R7");
        #1;
        chk("R8 no error on match", sync_err, 0);

        // R8: mismatching barrier, release still happens
        expect_issue(2'd0, 32'h404, "R8 release w0");
        expect_issue(2'd1, 32'h404, "R8 release w1");
        expect_issue(2'd2, 32'h404, "R8 release w2");
        expect_issue(2'd3, 32'h504, "R8 release w3");
        @(negedge clk);
        send_ret(2'd0, 32'h400, 2'd2);
        send_ret(2'd1, 32'h400, 2'd2);
        send_ret(2'd2, 32'h400, 2'd2);
        send_ret(2'd3, 32'h500, 2'd2);
        wait_drain("R8");
        #1;
        chk("R8 sync_err set", sync_err, 1);

        // R9: exits and done pulse
        @(negedge clk);
        send_ret(2'd0, 32'h0, 2'd3);
        send_ret(2'd1, 32'h0, 2'd3);
        send_ret(2'd2, 32'h0, 2'd3);
        #1;
        chk("R9 no done before last exit", done, 0);
        @(negedge clk);
        send_ret(2'd3, 32'h0, 2'd3);
        #1;
        chk("R9 done pulse", done, 1);
        chk("R9 no issue after exit", issue_valid, 0);
        @(negedge clk); #1;
        chk("R9 done one cycle", done, 0);

        // R1/R8: reset clears sticky flag
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        #1;
        chk("R1 sync_err after reset", sync_err, 0);
        chk("R1 issue_valid after reset", issue_valid, 0);
        chk("R1 done after reset", done, 0);
        repeat (3) @(negedge clk);
        chk("R10 scoreboard empty", 64'(exp_q.size()), 64'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule